// File: doc/BRIEF.md
# Rational-Ratio Modulo NCO

This block is a numerically controlled oscillator whose output rate is an exact rational fraction of its clock. A binary phase register advances by a fixed step on every enabled clock. Instead of wrapping naturally at a power of two, it is folded back by compare-and-subtract whenever it reaches a modulus. With the default step of 125 and modulus of 1944, a 155.52 MHz clock yields exactly 10 MHz. The edge-to-edge spacing of the output varies by one clock, and the whole pattern repeats every 1944 clocks (12.5 us at that clock rate).

The step and the modulus are parameters. A decimal modulus such as 1000 uses the same scheme, so frequencies that are exact in decimal can be produced without BCD arithmetic. The outputs are a square wave, a one-cycle pulse on every fold-back, and the current phase. All three are registered.

Top module: `rr_mod_nco`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `phase` = 0, `wrap` = 0 and `sq_out` = 1. This also holds while `en` is high.
- R2: On an enabled clock where `phase + STEP < MODULUS`, the next `phase` is `phase + STEP` and `wrap` is 0.
- R3: On an enabled clock where `phase + STEP >= MODULUS`, the next `phase` is `phase + STEP - MODULUS` and `wrap` is 1 for exactly that cycle. This includes the case where the sum equals MODULUS exactly, which gives a phase of 0.
- R4: On a clock with `en` low, `phase` and `sq_out` keep their values and `wrap` is 0, even when a fold-back would have been due.
- R5: `sq_out` is 1 exactly when the registered `phase` is below MODULUS/2 (972 by default), and 0 otherwise.
- R6: Starting from phase 0, any MODULUS enabled clocks contain exactly STEP wrap pulses and bring `phase` back to 0. By default that is 125 pulses in 1944 clocks.
- R7: `phase` is always below MODULUS.
- R8: With a decimal modulus (step 7, modulus 1000), the same behaviour holds: 7 pulses per 1000 enabled clocks, and a return to phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable |
| sq_out | output | 1 | Square-wave output, high in the lower half of the phase range |
| wrap | output | 1 | One-cycle pulse on each fold-back |
| phase | output | $clog2(MODULUS) | Current phase value |

## Verification
The bench first runs one full period of continuous enable from reset. This exposes the exact count of fold-backs, the return to phase 0, and the case where the sum lands exactly on the modulus. It then holds the enable low at the moment a fold-back is due, which separates a correct hold from a pulse leaking through. Random enable patterns follow, interleaving holds and steps at arbitrary phases, plus a reset asserted while enabled. A second instance with a decimal modulus shows that the fold-back does not depend on a power-of-two or on a particular step.

// File: rtl/nco_pkg.sv
package nco_pkg;
  parameter int NCO_DEF_STEP    = 125;
  parameter int NCO_DEF_MODULUS = 1944;

  function automatic int nco_half(input int m);
    return m / 2;
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int STEP    = 125,
  parameter int MODULUS = 1944,
  parameter int PW      = $clog2(MODULUS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [PW-1:0] phase_o,
  output logic [PW-1:0] phase_nx_o,
  output logic          wrap_o
);
  localparam int SW = PW + 1;
  localparam logic [PW:0]   STEP_X = SW'(STEP);
  localparam logic [PW:0]   MOD_X  = SW'(MODULUS);
  localparam logic [PW-1:0] LAST   = PW'(MODULUS - 1);

  logic [PW-1:0] phase_q;
  logic          wrap_q;
  logic [PW:0]   sum;
  logic          carry;
  logic [PW-1:0] folded;
  logic          wrap_nx;

  always_comb begin
    sum     = SW'(phase_q) + STEP_X;
    carry   = (sum >= MOD_X);
    folded  = carry ? PW'(sum - MOD_X) : PW'(sum);
    phase_nx_o = en ? folded : phase_q;
    wrap_nx = en && carry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= phase_nx_o;
      wrap_q  <= wrap_nx;
    end
  end

  assign phase_o = phase_q;
  assign wrap_o  = wrap_q;

  // window bookkeeping used only by the R6 check
  logic [PW-1:0] win_q;
  logic [PW-1:0] wcnt_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      wcnt_q <= '0;
    end else if (en) begin
      if (win_q == LAST) begin
        win_q  <= '0;
        wcnt_q <= '0;
      end else begin
        win_q  <= win_q + 1'b1;
        wcnt_q <= wcnt_q + PW'(wrap_nx);
      end
    end
  end

  a_r7_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    SW'(phase_q) < MOD_X);

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> ($stable(phase_q) && !wrap_q));

  a_r2_plain_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && !wrap_q) |->
      (SW'(phase_q) == SW'($past(phase_q)) + STEP_X));

  a_r3_fold_below_step: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (SW'(phase_q) < STEP_X));

  a_r6_window_count: assert property (@(posedge clk) disable iff (rst)
    (en && win_q == LAST) |-> ((SW'(wcnt_q) + SW'(wrap_nx)) == STEP_X));
endmodule

// File: rtl/nco_sq_slicer.sv
module nco_sq_slicer #(
  parameter int MODULUS = 1944,
  parameter int PW      = $clog2(MODULUS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] phase_nx_i,
  output logic          sq_o
);
  localparam logic [PW-1:0] HALF = PW'(nco_pkg::nco_half(MODULUS));

  always_ff @(posedge clk) begin
    if (rst) sq_o <= 1'b1;
    else     sq_o <= (phase_nx_i < HALF);
  end
endmodule

// File: rtl/rr_mod_nco.sv
module rr_mod_nco #(
  parameter int STEP    = nco_pkg::NCO_DEF_STEP,
  parameter int MODULUS = nco_pkg::NCO_DEF_MODULUS,
  parameter int PW      = $clog2(MODULUS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          sq_out,
  output logic          wrap,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] HALF = PW'(nco_pkg::nco_half(MODULUS));

  logic [PW-1:0] phase_nx;

  nco_phase_acc #(.STEP(STEP), .MODULUS(MODULUS), .PW(PW)) u_acc (
    .clk(clk), .rst(rst), .en(en),
    .phase_o(phase), .phase_nx_o(phase_nx), .wrap_o(wrap)
  );

  nco_sq_slicer #(.MODULUS(MODULUS), .PW(PW)) u_sq (
    .clk(clk), .rst(rst), .phase_nx_i(phase_nx), .sq_o(sq_out)
  );

  a_r5_sq_tracks_phase: assert property (@(posedge clk) disable iff (rst)
    sq_out == (phase < HALF));

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (phase == '0 && !wrap && sq_out));
endmodule

// File: tb/test_rr_mod_nco.sv
`timescale 1ns/1ps
module test_rr_mod_nco;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #2.5 clk = ~clk;

  logic        a_sq, a_wrap;
  logic [10:0] a_phase;
  logic        b_sq, b_wrap;
  logic [9:0]  b_phase;

  rr_mod_nco i_rr_mod_nco (
    .clk(clk), .rst(rst), .en(en),
    .sq_out(a_sq), .wrap(a_wrap), .phase(a_phase)
  );

  rr_mod_nco #(.STEP(7), .MODULUS(1000)) i_rr_mod_nco_dec (
    .clk(clk), .rst(rst), .en(en),
    .sq_out(b_sq), .wrap(b_wrap), .phase(b_phase)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ea_ph = 0, eb_ph = 0;
  bit ea_w = 0, eb_w = 0;
  bit last_en = 0;
  bit last_rst = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nxt(input int ph, input int st, input int md);
    int s = ph + st;
    return (s >= md) ? s - md : s;
  endfunction

  task automatic compare_all();
    string t;
    t = last_rst ? "R1" : (!last_en ? "R4" : (ea_w ? "R3" : "R2"));
    chk(a_phase == ea_ph, {t, " phase"}, a_phase, ea_ph);
    chk(a_wrap == ea_w, {t, " wrap"}, a_wrap, ea_w);
    chk(a_sq == (ea_ph < 972), "R5 sq", a_sq, ea_ph < 972);
    chk(a_phase < 1944, "R7 range", a_phase, 1943);
    t = last_rst ? "R1" : "R8";
    chk(b_phase == eb_ph, {t, " dec phase"}, b_phase, eb_ph);
    chk(b_wrap == eb_w, {t, " dec wrap"}, b_wrap, eb_w);
    chk(b_sq == (eb_ph < 500), "R8 dec sq", b_sq, eb_ph < 500);
  endtask

  task automatic tick(input bit e, input bit r);
    en  = e;
    rst = r;
    @(posedge clk);
    if (r) begin
      ea_ph = 0; eb_ph = 0; ea_w = 0; eb_w = 0;
    end else if (e) begin
      ea_w  = (ea_ph + 125 >= 1944);
      eb_w  = (eb_ph + 7 >= 1000);
      ea_ph = nxt(ea_ph, 125, 1944);
      eb_ph = nxt(eb_ph, 7, 1000);
    end else begin
      ea_w = 0; eb_w = 0;
    end
    last_en  = e;
    last_rst = r;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int wa, wb;
    void'($urandom(32'd24680));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    compare_all();
    chk(a_phase == 0 && !a_wrap && a_sq, "R1 reset", a_phase, 0);

    // R6 / R8: one full period of continuous enable
    wa = 0; wb = 0;
    for (int i = 0; i < 1944; i++) begin
      tick(1'b1, 1'b0);
      if (a_wrap) wa++;
      if (i < 1000 && b_wrap) wb++;
      if (i == 999) begin
        chk(wb == 7, "R8 wraps per 1000", wb, 7);
        chk(b_phase == 0, "R8 back to zero", b_phase, 0);
      end
    end
    chk(wa == 125, "R6 wraps per 1944", wa, 125);
    chk(a_phase == 0, "R6 back to zero", a_phase, 0);

    // R4: hold with a fold-back pending
    while (ea_ph + 125 < 1944) tick(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      tick(1'b0, 1'b0);
      chk(a_wrap == 1'b0, "R4 no pulse when idle", a_wrap, 0);
    end
    tick(1'b1, 1'b0);
    chk(a_wrap == 1'b1, "R3 pending fold after hold", a_wrap, 1);

    // random enable mix
    for (int i = 0; i < 3000; i++) tick($urandom_range(0, 3) != 0, 1'b0);

    // R1: reset while enabled
    tick(1'b1, 1'b1);
    chk(a_phase == 0 && b_phase == 0, "R1 reset under enable", a_phase, 0);
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule